// File: doc/BRIEF.md
# Register Bank with Set, Clear and Toggle Write Aliases

This block is the control register file of a peripheral. Each logical register is visible on a simple synchronous register bus at four word addresses. One word reads and writes the value as a whole. The other three words apply a bit mask: they set, clear or invert only the bits whose mask bit is 1. Software can therefore change single control bits without a read-modify-write sequence, and two agents that own different bits of the same register do not need a lock.

Register 0 carries two block-wide controls in its two most significant bits. The top bit is a soft reset. While it is 1, every other register is held at its reset value. The bit below it is an output freeze, which works as a clock gate: while it is 1, the register image presented to the peripheral datapath does not change. Register 0 stays writable throughout, so software can always leave either state. A hardware reset leaves both controls set.

Top module: `alias_regbank`

## Requirements
- R1: The byte address `addr` is split into fields: the register index is `addr[7:4]`, the alias selector is `addr[3:2]` (0 = whole value, 1 = set, 2 = clear, 3 = toggle), and `addr[1:0]` is ignored.
- R2: A write to alias 0 replaces the addressed register with `wdata`.
- R3: A write to alias 1 sets each register bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R4: A write to alias 2 clears each register bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R5: A write to alias 3 inverts each register bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R6: A read from any of the four aliases of a register returns the value the register held at the clock edge that accepts the read. `rdata` shows it one cycle later.
- R7: A write whose register index is `NUM_REGS` or more changes no register, and a read from such an address returns zero.
- R8: After a hardware reset, register 0 reads 0xC00000A5, with bit 31 (soft reset) and bit 30 (output freeze) both 1. Register i for i >= 1 reads i * 0x00010001.
- R9: While bit 31 of register 0 is 1, registers 1 and above are forced to their reset values from the next clock edge on, and writes to them have no effect. Bits 29:0 of register 0 are held at 0x000000A5, so clearing bit 31 leaves them at that value.
- R10: While bit 30 of register 0 is 1, `regs_o` does not change. All registers, register 0 included, can still be written and read.
- R11: `regs_o` holds register i in bits [32*i+31 : 32*i]. When bit 30 of register 0 is 0, `regs_o` follows the registers one clock later. `soft_rst_o` and `clk_gate_o` show bits 31 and 30 of register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data or bit mask |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| regs_o | output | 128 | Register image for the peripheral datapath |
| soft_rst_o | output | 1 | Soft reset control (register 0 bit 31) |
| clk_gate_o | output | 1 | Output freeze control (register 0 bit 30) |

## Verification
A register that holds a wrong value shows up on `rdata` one cycle after any read of any of its four aliases. When the freeze bit is clear, it also shows up on `regs_o` one cycle after the register changes. A fault in the soft-reset hold only becomes visible when a register is read, or when the image is updated, after a write that should have been blocked. For this reason the bench writes to the held registers and to register 0's low bits during soft reset, and reads them back afterwards. A fault in the freeze logic shows up as a change on `regs_o` during the frozen cycles. The bench then compares the image with the written registers once the freeze bit is cleared.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

  // Which view of a register an access targets; this encoding is what
  // the alias selector address bits carry.
  typedef enum logic [1:0] {
    ALIAS_WHOLE = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLR   = 2'd2,
    ALIAS_TOG   = 2'd3
  } alias_op_e;

  // Byte-address layout: 4-byte words, four alias words per register.
  localparam int unsigned WORD_LSB  = 2;
  localparam int unsigned ALIAS_W   = 2;
  localparam int unsigned SLOT_LSB  = WORD_LSB + ALIAS_W;

endpackage

// File: rtl/arb_decode.sv
module arb_decode
  import alias_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  output logic [NUM_REGS-1:0] wr_stb,
  output alias_op_e           op,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);

  localparam int unsigned SLOT_W = ADDR_W - SLOT_LSB;

  logic [SLOT_W-1:0] slot;
  logic              unused_byte_lane;

  assign slot             = addr[ADDR_W-1:SLOT_LSB];
  assign unused_byte_lane = ^addr[WORD_LSB-1:0];
  assign op               = alias_op_e'(addr[SLOT_LSB-1:WORD_LSB]);
  assign hit              = (32'(slot) < NUM_REGS);
  assign idx              = slot[IDX_W-1:0];

  // One strobe per register; an unmapped slot raises none.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
    assign wr_stb[g] = wr_en && (slot == SLOT_W'(g));
  end

endmodule

// File: rtl/arb_reg.sv
module arb_reg
  import alias_regbank_pkg::*;
#(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  RST_VAL = '0,
  parameter bit            IS_CTRL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_stb,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  input  logic         hold,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  always_comb begin
    unique case (op)
      ALIAS_SET: nxt = q | wdata;
      ALIAS_CLR: nxt = q & ~wdata;
      ALIAS_TOG: nxt = q ^ wdata;
      default:   nxt = wdata;
    endcase
  end

  if (IS_CTRL) begin : g_ctrl
    // Control register: the two top bits stay writable in soft reset,
    // the rest is pinned to its default until soft reset is released.
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= RST_VAL;
      end else if (wr_stb) begin
        q <= hold ? {nxt[W-1:W-2], RST_VAL[W-3:0]} : nxt;
      end else if (hold) begin
        q[W-3:0] <= RST_VAL[W-3:0];
      end
    end
  end else begin : g_plain
    always_ff @(posedge clk) begin
      if (rst || hold) begin
        q <= RST_VAL;
      end else if (wr_stb) begin
        q <= nxt;
      end
    end
  end

endmodule

// File: rtl/arb_rdmux.sv
module arb_rdmux #(
  parameter int unsigned W        = 32,
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_en,
  input  logic                         hit,
  input  logic [IDX_W-1:0]             idx,
  input  logic [NUM_REGS-1:0][W-1:0]   regs,
  output logic [W-1:0]                 rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= hit ? regs[idx] : '0;
    end
  end

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import alias_regbank_pkg::*;
#(
  parameter int unsigned          ADDR_W       = 8,
  parameter int unsigned          DATA_W       = 32,
  parameter int unsigned          NUM_REGS     = 4,
  parameter logic [DATA_W-3:0]    REG0_LOW_RST = 'hA5,
  parameter logic [DATA_W-1:0]    RST_STEP     = 'h0001_0001
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         wr_en,
  input  logic                         rd_en,
  output logic [DATA_W-1:0]            rdata,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o,
  output logic                         soft_rst_o,
  output logic                         clk_gate_o
);

  localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [DATA_W-1:0] REG0_RST = {2'b11, REG0_LOW_RST};

  typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

  function automatic bank_t reset_image();
    bank_t img;
    for (int i = 0; i < NUM_REGS; i++) begin
      img[i] = (i == 0) ? REG0_RST : DATA_W'(i) * RST_STEP;
    end
    return img;
  endfunction

  localparam bank_t RST_IMG = reset_image();

  logic [NUM_REGS-1:0] wr_stb;
  alias_op_e           op;
  logic                hit;
  logic [IDX_W-1:0]    idx;
  bank_t               reg_q;
  bank_t               img_q;
  logic                soft_hold;
  logic                freeze;

  arb_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .wr_stb (wr_stb),
    .op     (op),
    .hit    (hit),
    .idx    (idx)
  );

  assign soft_hold = reg_q[0][DATA_W-1];
  assign freeze    = reg_q[0][DATA_W-2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    arb_reg #(
      .W       (DATA_W),
      .RST_VAL (RST_IMG[g]),
      .IS_CTRL (g == 0)
    ) u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_stb (wr_stb[g]),
      .op     (op),
      .wdata  (wdata),
      .hold   (soft_hold),
      .q      (reg_q[g])
    );
  end

  arb_rdmux #(
    .W        (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .hit   (hit),
    .idx   (idx),
    .regs  (reg_q),
    .rdata (rdata)
  );

  // Image seen by the datapath: a registered copy that stops updating
  // while the freeze control is set.
  always_ff @(posedge clk) begin
    if (rst) begin
      img_q <= RST_IMG;
    end else if (!freeze) begin
      img_q <= reg_q;
    end
  end

  assign regs_o     = img_q;
  assign soft_rst_o = soft_hold;
  assign clk_gate_o = freeze;

endmodule

// File: rtl/alias_regbank_chk.sv
module alias_regbank_chk
  import alias_regbank_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       NUM_REGS = 4,
  parameter logic [DATA_W-1:0] RST_STEP = 'h0001_0001,
  parameter logic [DATA_W-1:0] REG0_RST = 'hC000_00A5
) (
  input logic                               clk,
  input logic                               rst,
  input logic [ADDR_W-1:0]                  addr,
  input logic [DATA_W-1:0]                  wdata,
  input logic                               wr_en,
  input logic                               rd_en,
  input logic [DATA_W-1:0]                  rdata,
  input logic [NUM_REGS-1:0][DATA_W-1:0]    reg_q,
  input logic [NUM_REGS*DATA_W-1:0]         regs_o,
  input logic                               soft_rst_o,
  input logic                               clk_gate_o
);

  localparam int unsigned IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned SLOT_W = ADDR_W - SLOT_LSB;

  logic [SLOT_W-1:0]  slot;
  logic               mapped;
  logic [1:0]         aop;
  logic [IDX_W-1:0]   prev_idx;
  logic [DATA_W-1:0]  prev_val;
  logic [DATA_W-1:0]  cur_sel;
  logic               others_rst;
  logic               unused_lane;

  assign slot        = addr[ADDR_W-1:SLOT_LSB];
  assign mapped      = (32'(slot) < NUM_REGS);
  assign aop         = addr[SLOT_LSB-1:WORD_LSB];
  assign unused_lane = ^addr[WORD_LSB-1:0];
  assign cur_sel     = reg_q[prev_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_idx <= '0;
      prev_val <= '0;
    end else begin
      prev_idx <= slot[IDX_W-1:0];
      prev_val <= mapped ? reg_q[slot[IDX_W-1:0]] : '0;
    end
  end

  always_comb begin
    others_rst = 1'b1;
    for (int i = 1; i < NUM_REGS; i++) begin
      if (reg_q[i] != DATA_W'(i) * RST_STEP) others_rst = 1'b0;
    end
  end

  a_r8_hw_reset: assert property (@(posedge clk)
    rst |=> (reg_q[0] == REG0_RST) && soft_rst_o && clk_gate_o);

  a_r2_whole_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mapped && aop == 2'd0 && !soft_rst_o) |=> cur_sel == $past(wdata));

  a_r3_set_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mapped && aop == 2'd1 && !soft_rst_o)
      |=> (cur_sel & $past(wdata)) == $past(wdata));

  a_r4_clr_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mapped && aop == 2'd2 && !soft_rst_o)
      |=> (cur_sel & $past(wdata)) == '0);

  a_r5_tog_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mapped && aop == 2'd3 && !soft_rst_o)
      |=> cur_sel == (prev_val ^ $past(wdata)));

  a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata == prev_val);

  a_r7_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);

  a_r7_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped && !soft_rst_o) |=> $stable(reg_q));

  a_r9_soft_hold: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> others_rst);

  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    clk_gate_o |=> $stable(regs_o));

endmodule

bind alias_regbank alias_regbank_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .RST_STEP (RST_STEP),
  .REG0_RST ({2'b11, REG0_LOW_RST})
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr),
  .wdata      (wdata),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .reg_q      (reg_q),
  .regs_o     (regs_o),
  .soft_rst_o (soft_rst_o),
  .clk_gate_o (clk_gate_o)
);

// File: tb/tb_alias_regbank.sv
module tb_alias_regbank;

  localparam int NREG = 4;
  localparam logic [31:0] R0_RST = 32'hC000_00A5;
  localparam logic [31:0] STEP   = 32'h0001_0001;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [31:0]       rdata;
  logic [NREG*32-1:0] regs_o;
  logic              soft_rst_o;
  logic              clk_gate_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m   [NREG];
  logic [31:0] img [NREG];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  alias_regbank dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .regs_o(regs_o),
    .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] a_of(input int idx, input int al);
    return {4'(idx), 2'(al), 2'b00};
  endfunction

  function automatic logic [31:0] alias_apply(input logic [1:0] op,
      input logic [31:0] cur, input logic [31:0] msk);
    case (op)
      2'd1: return cur | msk;
      2'd2: return cur & ~msk;
      2'd3: return cur ^ msk;
      default: return msk;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      m[i]   = (i == 0) ? R0_RST : 32'(i) * STEP;
      img[i] = m[i];
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    int idx;
    logic [31:0] nxt;
    idx = int'(a[7:4]);
    if (idx < NREG) begin
      if (idx == 0) begin
        nxt = alias_apply(a[3:2], m[0], d);
        m[0] = m[0][31] ? {nxt[31:30], R0_RST[29:0]} : nxt;
      end else if (!m[0][31]) begin
        m[idx] = alias_apply(a[3:2], m[idx], d);
      end
    end
    if (m[0][31]) begin
      m[0][29:0] = R0_RST[29:0];
      for (int i = 1; i < NREG; i++) m[i] = 32'(i) * STEP;
    end
    if (!m[0][30]) begin
      for (int i = 0; i < NREG; i++) img[i] = m[i];
    end
  endtask

  // Driver: one write, then idle cycles so forced values and the image settle.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Driver: one read; the expected word goes to the scoreboard queue.
  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_img(input string tag);
    @(negedge clk);
    for (int i = 0; i < NREG; i++) check(tag, regs_o[i*32 +: 32], img[i]);
  endtask

  // Monitor: pops one expected word per accepted read.
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard underflow", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8: reset state at the pins and through reads
    @(negedge clk);
    check("R8 soft_rst_o", 32'(soft_rst_o), 32'd1);
    check("R8 clk_gate_o", 32'(clk_gate_o), 32'd1);
    check_img("R8 R11 image after reset");
    for (int i = 0; i < NREG; i++) bus_read(a_of(i, 0), m[i], "R8 reset value");

    // R9: writes to held registers and to reg0 low bits do nothing
    bus_write(a_of(1, 0), 32'hDEAD_BEEF);
    bus_read(a_of(1, 0), 32'h0001_0001, "R9 write ignored in soft reset");
    bus_write(a_of(0, 0), 32'hC000_FFFF);
    bus_read(a_of(0, 0), 32'hC000_00A5, "R9 reg0 low bits held");

    // Release soft reset; freeze stays on
    bus_write(a_of(0, 2), 32'h8000_0000);
    bus_read(a_of(0, 0), 32'h4000_00A5, "R4 R9 release keeps defaults");
    check("R11 soft_rst_o low", 32'(soft_rst_o), 32'd0);

    // R10: writes land while the image stays frozen
    bus_write(a_of(1, 0), 32'h1234_5678);
    bus_read(a_of(1, 0), 32'h1234_5678, "R2 R10 write while frozen");
    check("R10 image frozen", regs_o[32 +: 32], 32'h0001_0001);
    bus_write(a_of(0, 2), 32'h4000_0000);
    check_img("R10 R11 image resumes");

    // R1 R6: every alias (and byte lanes) reads the same value
    for (int al = 0; al < 4; al++) bus_read(a_of(1, al), m[1], "R1 R6 alias read");
    bus_read(a_of(1, 1) | 8'h03, m[1], "R1 byte lane ignored");

    // R3 R4 R5 on two registers with distinct masks
    bus_write(a_of(1, 1), 32'h0000_00FF);
    bus_read(a_of(1, 0), m[1], "R3 set");
    bus_write(a_of(1, 2), 32'h0F0F_0000);
    bus_read(a_of(1, 0), m[1], "R4 clear");
    bus_write(a_of(1, 3), 32'hFFFF_0000);
    bus_read(a_of(1, 0), m[1], "R5 toggle");
    bus_write(a_of(2, 0), 32'hA5A5_5A5A);
    bus_write(a_of(2, 3), 32'h0000_FFFF);
    bus_write(a_of(2, 1), 32'h0100_0001);
    bus_write(a_of(3, 2), 32'hFFFF_FFFF);
    bus_read(a_of(2, 2), m[2], "R3 R5 reg2");
    bus_read(a_of(3, 3), 32'h0, "R4 reg3 cleared");
    check_img("R11 image follows");

    // R7: unmapped accesses
    bus_write(8'h40, 32'hFFFF_FFFF);
    bus_write(8'h7C, 32'hFFFF_FFFF);
    bus_read(8'h40, 32'h0, "R7 unmapped read");
    bus_read(8'hF4, 32'h0, "R7 unmapped read high");
    for (int i = 0; i < NREG; i++) bus_read(a_of(i, 0), m[i], "R7 no register changed");

    // R9: re-enter soft reset via the set alias
    bus_write(a_of(0, 0), 32'h0000_3C3C);
    bus_read(a_of(0, 0), 32'h0000_3C3C, "R2 reg0 whole write");
    bus_write(a_of(0, 1), 32'h8000_0000);
    bus_read(a_of(0, 0), 32'h8000_00A5, "R9 reg0 low defaults");
    bus_read(a_of(2, 0), 32'h0002_0002, "R9 reg2 forced");
    check_img("R9 R11 image of forced regs");
    bus_write(a_of(0, 2), 32'h8000_0000);
    bus_read(a_of(0, 0), 32'h0000_00A5, "R9 release");

    // R10: freeze set by the toggle alias, then write reg3
    bus_write(a_of(0, 3), 32'h4000_0000);
    check("R11 clk_gate_o", 32'(clk_gate_o), 32'd1);
    bus_write(a_of(3, 3), 32'h00FF_00FF);
    bus_read(a_of(3, 0), m[3], "R10 write while frozen");
    check("R10 reg3 image frozen", regs_o[96 +: 32], img[3]);

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule